// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32,768 eight-bit words. The host issues one word per request through a valid/ready handshake: an address, a write flag and, for writes, a data byte. The controller turns each request into the sequence of address, chip select, write enable and output enable levels that the RAM needs. It also controls the shared data lines through a drive-enable output, so the tri-state buffer sits outside the block. Read data returns to the host with a one-cycle valid pulse.

Every timing window is a whole number of clock cycles set by a parameter. These cover the read access time, the write pulse width, the write recovery time and the bus turnaround after a read. Output enable stays high for the whole of every write, which lets the shorter write-pulse rating apply. The data drive only begins once the RAM's outputs have had the configured number of cycles to release the lines after a read.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only in a cycle with `req_valid` and `req_ready` both 1. `req_ready` stays 0 from that cycle's edge until the access, including its recovery, has completed. A request presented while `req_ready` is 0 has no effect on the memory contents.
- R3: A read (`req_write` = 0) holds `mem_cs_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 with the request address for `ACC_CYC` cycles. It then samples `mem_dq_in`. `rsp_valid` is 1 for exactly one cycle, `ACC_CYC` cycles after the accepting edge, with the sampled byte on `rsp_rdata`.
- R4: During a write (`req_write` = 1), `mem_we_n` is 0 for exactly `WP_CYC` consecutive cycles while `mem_cs_n` is 0, and `mem_oe_n` is 1 whenever `mem_we_n` is 0.
- R5: `mem_dq_oe` is 1, with the write byte on `mem_dq_out`, in the cycle before `mem_we_n` falls and in every cycle that `mem_we_n` is 0.
- R6: After `mem_we_n` rises, `mem_addr` and the data drive stay unchanged for `REC_CYC` cycles with `mem_cs_n` = 1.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It becomes 1 only after `mem_oe_n` has been 1 for at least `TURN_CYC` cycles.
- R8: `mem_we_n` is 0 only while `mem_cs_n` is 0. When no access is in progress, `mem_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Read data, held until the next read |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the external data-line driver |
| mem_dq_in | input | DATA_W | Data lines as seen from the RAM |

## Verification
The properties assume that the host changes nothing at the block's inputs other than through the handshake. They also assume that reset is a clean synchronous pulse. The bench drives inputs only at falling edges and waits for `req_ready` before raising `req_valid`, so every request is taken at a well-defined edge. Its RAM model returns valid data only after output enable has been low for the access count, and a filler byte before that. A controller that samples early therefore returns visibly wrong data, and the strobe sequences stay inside the legal mode table.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_END   = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_REC   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Width of a counter able to hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels per state; output enable stays high for every write state
    function automatic strobe_t strobes_for(input seq_state_e st, input logic turn_ok);
        strobe_t s;
        s = STROBE_OFF;
        case (st)
            ST_RD_ACC: begin
                s.cs_n = 1'b0;
                s.oe_n = 1'b0;
            end
            ST_WR_SETUP: begin
                s.cs_n  = 1'b0;
                s.dq_oe = turn_ok;
            end
            ST_WR_PULSE: begin
                s.cs_n  = 1'b0;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            ST_WR_REC: begin
                s.dq_oe = 1'b1;
            end
            default: s = STROBE_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic release_start,
    output logic drive_ok
);
    localparam int TW = sram_ctrl_pkg::cnt_width(TURN_CYC);
    localparam logic [TW-1:0] TURN_LOAD = TW'(TURN_CYC);

    logic [TW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (release_start) begin
            wait_q <= TURN_LOAD;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign drive_ok = (wait_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CYC = 2,
    parameter int WP_CYC  = 1,
    parameter int REC_CYC = 1,
    parameter int CNT_W   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       timer_zero,
    input  logic       drive_ok,
    output logic       accept,
    output logic       timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic       capture,
    output logic       release_start,
    output seq_state_e state
);
    localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d       = state_q;
        accept        = 1'b0;
        timer_load    = 1'b0;
        timer_val     = '0;
        capture       = 1'b0;
        release_start = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d    = ST_RD_ACC;
                        timer_load = 1'b1;
                        timer_val  = ACC_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (timer_zero) begin
                    capture       = 1'b1;
                    release_start = 1'b1;
                    state_d       = ST_RD_END;
                end
            end
            ST_RD_END: state_d = ST_IDLE;
            ST_WR_SETUP: begin
                if (drive_ok) begin
                    state_d    = ST_WR_PULSE;
                    timer_load = 1'b1;
                    timer_val  = WP_LOAD;
                end
            end
            ST_WR_PULSE: begin
                if (timer_zero) begin
                    state_d    = ST_WR_REC;
                    timer_load = 1'b1;
                    timer_val  = REC_LOAD;
                end
            end
            ST_WR_REC: begin
                if (timer_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int ACC_CYC  = 2,
    parameter int WP_CYC   = 1,
    parameter int REC_CYC  = 1,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_WIN = max2(ACC_CYC, max2(WP_CYC, REC_CYC));
    localparam int CNT_W   = cnt_width(MAX_WIN);

    seq_state_e       state;
    strobe_t          strb;
    logic             accept, timer_load, timer_zero, capture, release_start, drive_ok;
    logic [CNT_W-1:0] timer_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    sram_seq_fsm #(
        .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .timer_zero(timer_zero), .drive_ok(drive_ok),
        .accept(accept), .timer_load(timer_load), .timer_val(timer_val),
        .capture(capture), .release_start(release_start), .state(state)
    );

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst),
        .load(timer_load), .load_val(timer_val), .zero(timer_zero)
    );

    sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk(clk), .rst(rst),
        .release_start(release_start), .drive_ok(drive_ok)
    );

    // Request fields are held for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= mem_dq_in;
    end

    // Strobes decode straight from the state register (Moore outputs)
    assign strb       = strobes_for(state, drive_ok);
    assign mem_cs_n   = strb.cs_n;
    assign mem_we_n   = strb.we_n;
    assign mem_oe_n   = strb.oe_n;
    assign mem_dq_oe  = strb.dq_oe;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign req_ready  = (state == ST_IDLE);
    assign rsp_valid  = (state == ST_RD_END);
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    localparam int GW = sram_ctrl_pkg::cnt_width(TURN_CYC);
    localparam logic [GW-1:0] GAP_MAX = GW'(TURN_CYC);

    // Cycles that output enable has been high, saturating at TURN_CYC
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                gap_q <= GAP_MAX;
        else if (!mem_oe_n)     gap_q <= '0;
        else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_single_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    p_data_before_we_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

    p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ($stable(mem_addr) && mem_dq_oe && mem_cs_n));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (gap_q >= GAP_MAX));

    p_we_inside_cs_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);
endmodule

bind sram_ctrl sram_ctrl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC)
) u_checker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 6;
    localparam int DW   = 8;
    localparam int ACC  = 3;
    localparam int WP   = 2;
    localparam int REC  = 2;
    localparam int TURN = 3;
    localparam int NW   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .WP_CYC(WP),
        .REC_CYC(REC), .TURN_CYC(TURN)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return DW'((a * 37 + 11 + pass * 91) & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // RAM model: data appears only after output enable has been low ACC cycles
    logic [DW-1:0] ram [NW];
    int oe_low = 0;
    assign mem_dq_in = (oe_low >= ACC) ? ram[mem_addr] : 8'hEE;

    // Interface monitors, sampled at falling edges
    int  we_run = 0;
    int  oe_high_run = 0;
    bit  prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_oe_n && mem_we_n) oe_low++;
            else oe_low = 0;
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) ram[mem_addr] = mem_dq_out;

            // R4 write pulse width and output enable high during write
            if (!mem_we_n) begin
                we_run++;
                if (!mem_oe_n) check(0, "R4 oe_n during write", 0, 1);
                if (mem_cs_n)  check(0, "R8 we_n low outside cs", 1, 0);
            end else if (we_run > 0) begin
                check(we_run == WP, "R4 write pulse cycles", we_run, WP);
                we_run = 0;
            end
            // R5 data driven before and during the pulse
            if (!mem_we_n && prev_we_n) check(prev_dq_oe && mem_dq_oe, "R5 drive before we", prev_dq_oe, 1);
            // R6 hold after write end
            if (mem_we_n && !prev_we_n)
                check(mem_addr == prev_addr && mem_dq_oe && mem_cs_n, "R6 hold after we", mem_addr, prev_addr);
            // R7 contention and turnaround
            if (mem_dq_oe && !mem_oe_n) check(0, "R7 drive with oe low", 1, 0);
            if (mem_dq_oe && !prev_dq_oe && oe_high_run < 1000)
                check(oe_high_run >= TURN, "R7 turnaround gap", oe_high_run, TURN);
            if (!mem_oe_n) oe_high_run = 0;
            else if (oe_high_run < 1000) oe_high_run++;
            prev_we_n  = mem_we_n;
            prev_dq_oe = mem_dq_oe;
            prev_addr  = mem_addr;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after write accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        check(mem_cs_n, "R8 idle deselect", mem_cs_n, 1);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp);
        int lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after read accept", req_ready, 0);
        check(!mem_cs_n && !mem_oe_n && mem_we_n && mem_addr == AW'(a), "R3 read strobes", mem_addr, a);
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        check(lat == ACC, "R3 response latency", lat, ACC);
        check(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
        @(negedge clk);
        check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
              "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        check(mem_cs_n && !mem_dq_oe && req_ready && !rsp_valid, "R1 after reset", mem_cs_n, 1);

        // Pass 0: write then read each address back to back (exercises turnaround)
        for (int a = 0; a < NW; a++) begin
            do_write(a, pat(a, 0));
            do_read(a, pat(a, 0));
        end
        // Pass 1: all writes, then all reads in reverse order
        for (int a = 0; a < NW; a++) do_write(a, pat(a, 1));
        for (int a = NW - 1; a >= 0; a--) do_read(a, pat(a, 1));

        // R2: a write presented while busy must be ignored
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(9);
        @(negedge clk);
        req_write = 1'b1; req_addr = AW'(5); req_wdata = 8'h00;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        check(rsp_rdata == pat(9, 1), "R2 read under busy stimulus", rsp_rdata, pat(9, 1));
        do_read(5, pat(5, 1));
        check(1, "R2 busy write ignored", 0, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule